// File: doc/BRIEF.md
# SDRAM Command Decoder and Protocol Checker

This block sits beside the command pins of a four-bank synchronous DRAM and samples them on every rising clock edge. It turns each cycle's pins into one command code: mode register set, auto refresh, self refresh entry or exit, bank activate, read or write (each with or without auto precharge), burst stop, single-bank precharge, all-bank precharge, or no operation. The code appears on a registered output one edge later.

Alongside the decode, the block keeps a small state machine per bank. The bank states are `B_IDLE`, `B_OPEN` and `B_AUTOPRE`. The transitions are activate (idle to open), plain precharge (open to idle), read or write with auto precharge (open to autopre), and countdown expiry (autopre to idle). A global state machine has the states `G_RUN`, `G_MRS_GAP` and `G_SELF`. Its transitions are an accepted mode register set (run to gap), the following edge (gap to run), an accepted self refresh entry (run to self) and clock enable returning high (self to run).

Every command that breaks a protocol rule raises a violation flag and a code. A flagged command has no effect on any state. The block is meant for simulation monitors and for on-chip protocol checking next to a memory controller.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Pins are read as {cs_n, ras_n, cas_n, we_n}: 0000 mode set, 0001 refresh, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0111 and any cs_n=1 no operation. When clock enable was low on the previous edge outside self refresh, the cycle is no operation. cmd_o after an edge gives the command sampled at that edge: 0 nop, 1 mode set, 2 auto refresh, 3 self refresh entry, 4 self refresh exit, 5 activate, 6 read, 7 read+autoprecharge, 8 write, 9 write+autoprecharge, 10 burst stop, 11 precharge, 12 precharge all.
- R2: Bank index from {ba[1], ba[0]}: 00 gives bank 0, 10 gives bank 1, 01 gives bank 2, 11 gives bank 3. Bank n is bit n of bank_open_o and bank_ap_o.
- R3: Precharge with a10=1 closes every open bank whatever ba holds. With a10=0 it closes only the selected bank. Neither form is ever a violation outside the mode-set gap, and neither affects a bank in its countdown.
- R4: Activate on an idle bank opens it. Activate on an open or counting bank gives viol_code_o=5 and changes nothing. viol_o is high exactly when viol_code_o is nonzero.
- R5: Read or write to an idle bank gives viol_code_o=4 and changes nothing.
- R6: Read or write with a10=1 on an open bank starts its countdown (bank_ap_o=1, bank_open_o=0). When the command is accepted at edge k, the bank is idle after edge k+BURST_LEN+T_RP-1. With a10=0 the bank stays open.
- R7: Read or write to a bank in its countdown gives viol_code_o=3 and is ignored.
- R8: Mode set, auto refresh and self refresh entry with any bank open or counting give viol_code_o=2 and are ignored. With all banks idle they are accepted.
- R9: In the cycle after an accepted mode set, any command other than no operation gives viol_code_o=1 and is ignored. This code takes priority over every other code. The cycle after that is unrestricted.
- R10: Refresh pins with clock enable high on the previous edge and low now are self refresh entry, and self_ref_o rises. While clock enable stays low the pins are ignored and cmd_o is 0. The first edge with clock enable high is the exit (cmd_o=4) and clears self_ref_o.
- R11: Burst stop is never a violation and changes no bank state.
- R12: After reset all outputs are zero and all banks are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10 / auto precharge / all banks |
| ba | input | 2 | Bank select bits |
| cmd_o | output | 4 | Command decoded at the last edge |
| viol_o | output | 1 | Last command broke a rule |
| viol_code_o | output | 3 | Which rule was broken |
| bank_open_o | output | 4 | Banks with an open row |
| bank_ap_o | output | 4 | Banks draining an auto precharge burst |
| self_ref_o | output | 1 | Device is in self refresh |

## Verification
Two functions can meet on a single edge. The first is a bank's auto-precharge countdown expiring while a new read lands on that same bank. The second is an all-bank precharge arriving while one bank is counting and others are open. The bench provokes the first directly: it issues reads at the last counting edge and at the first idle edge, and expects code 3 and then code 4. Random traffic provokes the second, and a reference model in the bench judges every edge on the command code, the violation code and both bank vectors.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_MRS      = 4'd1,
        CMD_AREF     = 4'd2,
        CMD_SREF_IN  = 4'd3,
        CMD_SREF_OUT = 4'd4,
        CMD_ACT      = 4'd5,
        CMD_RD       = 4'd6,
        CMD_RDA      = 4'd7,
        CMD_WR       = 4'd8,
        CMD_WRA      = 4'd9,
        CMD_BST      = 4'd10,
        CMD_PRE      = 4'd11,
        CMD_PALL     = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE     = 3'd0,
        V_MRS_GAP  = 3'd1,
        V_NOT_IDLE = 3'd2,
        V_AP_LOCK  = 3'd3,
        V_NO_ROW   = 3'd4,
        V_ROW_OPEN = 3'd5
    } viol_e;

    typedef enum logic [1:0] {
        G_RUN     = 2'd0,
        G_MRS_GAP = 2'd1,
        G_SELF    = 2'd2
    } glob_e;

    typedef enum logic [1:0] {
        B_IDLE    = 2'd0,
        B_OPEN    = 2'd1,
        B_AUTOPRE = 2'd2
    } bank_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic       cke_prev,
    input  logic       cke,
    input  logic       in_self,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       a10,
    input  logic [1:0] ba,
    output cmd_e       cmd,
    output logic [1:0] bank
);

    // BA1=1/BA0=0 is bank 1 and BA0=1/BA1=0 is bank 2
    assign bank = {ba[0], ba[1]};

    always_comb begin
        cmd = CMD_NOP;
        if (in_self) begin
            cmd = cke ? CMD_SREF_OUT : CMD_NOP;
        end else if (cke_prev && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF_IN;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
                3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_mon_pkg::*;
#(
    parameter int AP_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic rw_i,
    input  logic ap_i,
    input  logic pre_i,
    output logic idle_o,
    output logic open_o,
    output logic ap_o
);

    localparam int CW = (AP_CYCLES > 2) ? $clog2(AP_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(AP_CYCLES - 2);

    bank_e         state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            B_IDLE: begin
                if (act_i) state_d = B_OPEN;
            end
            B_OPEN: begin
                if (rw_i && ap_i) begin
                    state_d = B_AUTOPRE;
                    cnt_d   = LOAD;
                end else if (pre_i) begin
                    state_d = B_IDLE;
                end
            end
            B_AUTOPRE: begin
                if (cnt_q == '0) state_d = B_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        idle_o = (state_q == B_IDLE);
        open_o = (state_q == B_OPEN);
        ap_o   = (state_q == B_AUTOPRE);
    end

    // R4: the top only forwards an activate to an idle bank
    p_act_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> idle_o);
    // R5: the top never forwards a read or write to an idle bank
    p_rw_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rw_i |-> !idle_o);
    // R6: a draining bank only ever ends in idle
    p_ap_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ap_o |=> (ap_o || idle_o));
    // R7: no read or write reaches a draining bank
    p_ap_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rw_i |-> !ap_o);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       a10,
    input  logic [1:0] ba,
    output logic [3:0] cmd_o,
    output logic       viol_o,
    output logic [2:0] viol_code_o,
    output logic [3:0] bank_open_o,
    output logic [3:0] bank_ap_o,
    output logic       self_ref_o
);

    localparam int NUM_BANKS = 4;
    localparam int AP_CYCLES = BURST_LEN + T_RP;

    glob_e                gstate_q, gstate_d;
    logic                 cke_q;
    cmd_e                 dcmd;
    logic [1:0]           bidx;
    viol_e                code;
    logic                 ok;
    logic                 is_rw, is_ap;
    logic [NUM_BANKS-1:0] idle_v, open_v, ap_v;
    cmd_e                 cmd_q;
    viol_e                code_q;

    sdram_cmd_decode u_dec (
        .cke_prev (cke_q),
        .cke      (cke),
        .in_self  (gstate_q == G_SELF),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (a10),
        .ba       (ba),
        .cmd      (dcmd),
        .bank     (bidx)
    );

    assign is_rw = (dcmd == CMD_RD) || (dcmd == CMD_RDA) ||
                   (dcmd == CMD_WR) || (dcmd == CMD_WRA);
    assign is_ap = (dcmd == CMD_RDA) || (dcmd == CMD_WRA);

    // rule check, gap rule first
    always_comb begin
        code = V_NONE;
        if (gstate_q == G_MRS_GAP && dcmd != CMD_NOP) begin
            code = V_MRS_GAP;
        end else begin
            unique case (dcmd)
                CMD_MRS, CMD_AREF, CMD_SREF_IN:
                    if (!(&idle_v)) code = V_NOT_IDLE;
                CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:
                    if (ap_v[bidx])        code = V_AP_LOCK;
                    else if (idle_v[bidx]) code = V_NO_ROW;
                CMD_ACT:
                    if (!idle_v[bidx]) code = V_ROW_OPEN;
                default: code = V_NONE;
            endcase
        end
    end
    assign ok = (code == V_NONE);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        assign sel = (bidx == 2'(g));
        sdram_bank_fsm #(.AP_CYCLES(AP_CYCLES)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_i  (ok && dcmd == CMD_ACT && sel),
            .rw_i   (ok && is_rw && sel),
            .ap_i   (is_ap),
            .pre_i  (ok && ((dcmd == CMD_PRE && sel) || dcmd == CMD_PALL)),
            .idle_o (idle_v[g]),
            .open_o (open_v[g]),
            .ap_o   (ap_v[g])
        );
    end

    // global state machine: next state
    always_comb begin
        gstate_d = gstate_q;
        unique case (gstate_q)
            G_RUN: begin
                if (ok && dcmd == CMD_MRS)          gstate_d = G_MRS_GAP;
                else if (ok && dcmd == CMD_SREF_IN) gstate_d = G_SELF;
            end
            G_MRS_GAP: gstate_d = G_RUN;
            G_SELF: begin
                if (dcmd == CMD_SREF_OUT) gstate_d = G_RUN;
            end
            default: gstate_d = G_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gstate_q <= G_RUN;
            cke_q    <= 1'b1;
            cmd_q    <= CMD_NOP;
            code_q   <= V_NONE;
        end else begin
            gstate_q <= gstate_d;
            cke_q    <= cke;
            cmd_q    <= dcmd;
            code_q   <= code;
        end
    end

    // outputs
    always_comb begin
        cmd_o       = cmd_q;
        viol_code_o = code_q;
        viol_o      = (code_q != V_NONE);
        bank_open_o = open_v;
        bank_ap_o   = ap_v;
        self_ref_o  = (gstate_q == G_SELF);
    end

    // R9: after an accepted mode set only a nop passes unflagged
    p_mrs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_MRS && code_q == V_NONE) |=>
        (cmd_q == CMD_NOP || code_q == V_MRS_GAP));
    // R10: self refresh is only ever held with every bank idle
    p_sref_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        self_ref_o |-> (bank_open_o == '0 && bank_ap_o == '0));
    // R3: an accepted precharge-all leaves no open row
    p_pall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PALL && code_q == V_NONE) |-> (open_v == '0));

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

    localparam int BL = 4;
    localparam int TRP = 2;
    localparam int NAP = BL + TRP;

    localparam logic [3:0] P_MRS = 4'b0000, P_REF = 4'b0001, P_ACT = 4'b0011,
                           P_RD  = 4'b0101, P_WR  = 4'b0100, P_BST = 4'b0110,
                           P_PRE = 4'b0010, P_NOP = 4'b0111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'b00;
    logic [3:0] cmd_o, bank_open_o, bank_ap_o;
    logic       viol_o, self_ref_o;
    logic [2:0] viol_code_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state: 0 idle, 1 open, 2 draining
    int m_bst[4];
    int m_cnt[4];
    int m_g = 0;
    bit m_ckeq = 1;

    always #4 clk = ~clk;

    sdram_cmd_monitor #(.BURST_LEN(BL), .T_RP(TRP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba), .cmd_o(cmd_o),
        .viol_o(viol_o), .viol_code_o(viol_code_o), .bank_open_o(bank_open_o),
        .bank_ap_o(bank_ap_o), .self_ref_o(self_ref_o)
    );

    task automatic check(input bit good, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_for(input int c, input int code);
        case (code)
            1: return "R9";
            2: return "R8";
            3: return "R7";
            4: return "R5";
            5: return "R4";
            default: ;
        endcase
        case (c)
            1, 2:         return "R8";
            3, 4:         return "R10";
            5:            return "R4";
            6, 7, 8, 9:   return "R6";
            10:           return "R11";
            11, 12:       return "R3";
            default:      return "R1";
        endcase
    endfunction

    task automatic model(input bit k, input logic [3:0] p, input bit a,
                         input logic [1:0] bsel, output int ec, output int ecode);
        int  b;
        bit  allidle;
        b = {bsel[0], bsel[1]};
        ec = 0;
        if (m_g == 2) ec = k ? 4 : 0;
        else if (m_ckeq && !p[3]) begin
            case (p[2:0])
                3'b000: ec = 1;
                3'b001: ec = k ? 2 : 3;
                3'b011: ec = 5;
                3'b101: ec = a ? 7 : 6;
                3'b100: ec = a ? 9 : 8;
                3'b110: ec = 10;
                3'b010: ec = a ? 12 : 11;
                default: ec = 0;
            endcase
        end
        allidle = 1;
        for (int i = 0; i < 4; i++) if (m_bst[i] != 0) allidle = 0;
        ecode = 0;
        if (m_g == 1 && ec != 0) ecode = 1;
        else if ((ec == 1 || ec == 2 || ec == 3) && !allidle) ecode = 2;
        else if (ec >= 6 && ec <= 9 && m_bst[b] == 2) ecode = 3;
        else if (ec >= 6 && ec <= 9 && m_bst[b] == 0) ecode = 4;
        else if (ec == 5 && m_bst[b] != 0) ecode = 5;
        for (int i = 0; i < 4; i++) begin
            if (m_bst[i] == 2) begin
                if (m_cnt[i] == 0) m_bst[i] = 0;
                else m_cnt[i] = m_cnt[i] - 1;
            end else if (ecode == 0) begin
                if (ec == 5 && i == b) m_bst[i] = 1;
                else if (m_bst[i] == 1 && (ec == 7 || ec == 9) && i == b) begin
                    m_bst[i] = 2;
                    m_cnt[i] = NAP - 2;
                end else if ((ec == 11 && i == b) || ec == 12) m_bst[i] = 0;
            end
        end
        if (m_g == 0) begin
            if (ecode == 0 && ec == 1) m_g = 1;
            else if (ecode == 0 && ec == 3) m_g = 2;
        end else if (m_g == 1) m_g = 0;
        else if (ec == 4) m_g = 0;
        m_ckeq = k;
    endtask

    task automatic step(input logic [3:0] p, input bit a, input logic [1:0] bsel,
                        input bit k, input string tag_in);
        int ec, ecode;
        logic [3:0] eo, ea;
        string tag;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
        a10 = a; ba = bsel; cke = k;
        model(k, p, a, bsel, ec, ecode);
        for (int i = 0; i < 4; i++) begin
            eo[i] = (m_bst[i] == 1);
            ea[i] = (m_bst[i] == 2);
        end
        tag = (tag_in == "") ? tag_for(ec, ecode) : tag_in;
        @(posedge clk);
        #1;
        check(cmd_o == 4'(ec), tag, "cmd_o", int'(cmd_o), ec);
        check(viol_code_o == 3'(ecode), tag, "viol_code_o", int'(viol_code_o), ecode);
        check(viol_o == (ecode != 0), "R4", "viol_o", int'(viol_o), int'(ecode != 0));
        check(bank_open_o == eo, tag, "bank_open_o", int'(bank_open_o), int'(eo));
        check(bank_ap_o == ea, tag, "bank_ap_o", int'(bank_ap_o), int'(ea));
        check(self_ref_o == (m_g == 2), "R10", "self_ref_o", int'(self_ref_o), int'(m_g == 2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] pins;
        int r;
        for (int i = 0; i < 4; i++) begin m_bst[i] = 0; m_cnt[i] = 0; end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        check(cmd_o == 4'd0 && viol_o == 1'b0 && viol_code_o == 3'd0, "R12", "cmd/viol",
              int'(cmd_o), 0);
        check(bank_open_o == 4'd0 && bank_ap_o == 4'd0 && self_ref_o == 1'b0, "R12",
              "banks", int'(bank_open_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 bank mapping
        step(P_ACT, 0, 2'b00, 1, "R2");
        check(bank_open_o == 4'b0001, "R2", "ba=00", int'(bank_open_o), 1);
        step(P_ACT, 0, 2'b10, 1, "R2");
        check(bank_open_o == 4'b0011, "R2", "ba=10", int'(bank_open_o), 3);
        step(P_ACT, 0, 2'b01, 1, "R2");
        check(bank_open_o == 4'b0111, "R2", "ba=01", int'(bank_open_o), 7);
        step(P_ACT, 0, 2'b11, 1, "R2");
        // R4 double activate
        step(P_ACT, 0, 2'b00, 1, "R4");
        check(viol_code_o == 3'd5, "R4", "reactivate", int'(viol_code_o), 5);
        // R11 burst stop with open rows
        step(P_BST, 0, 2'b00, 1, "R11");
        // R3 single then all
        step(P_PRE, 0, 2'b01, 1, "R3");
        check(bank_open_o == 4'b1011, "R3", "single pre", int'(bank_open_o), 11);
        step(P_PRE, 1, 2'b00, 1, "R3");
        check(bank_open_o == 4'b0000, "R3", "a10 override", int'(bank_open_o), 0);
        // R5 read idle bank
        step(P_RD, 0, 2'b00, 1, "R5");
        // R6 / R7 auto precharge window
        step(P_ACT, 0, 2'b11, 1, "R6");
        step(P_WR, 1, 2'b11, 1, "R6");
        step(P_RD, 0, 2'b11, 1, "R7");
        step(P_MRS, 0, 2'b00, 1, "R8");
        for (int i = 3; i <= NAP - 2; i++) step(P_NOP, 0, 2'b00, 1, "R6");
        check(bank_ap_o == 4'b1000, "R6", "still draining", int'(bank_ap_o), 8);
        step(P_RD, 1, 2'b11, 1, "R7");
        check(viol_code_o == 3'd3, "R7", "last drain edge", int'(viol_code_o), 3);
        step(P_RD, 0, 2'b11, 1, "R6");
        check(viol_code_o == 3'd4, "R6", "first idle edge", int'(viol_code_o), 4);
        // R9 mode set gap
        step(P_MRS, 0, 2'b00, 1, "R9");
        step(P_ACT, 0, 2'b00, 1, "R9");
        check(viol_code_o == 3'd1, "R9", "gap", int'(viol_code_o), 1);
        step(P_ACT, 0, 2'b00, 1, "R9");
        step(P_REF, 0, 2'b00, 1, "R8");
        step(P_PRE, 1, 2'b00, 1, "R3");
        step(P_REF, 0, 2'b00, 1, "R8");
        // R10 self refresh
        step(P_REF, 0, 2'b00, 0, "R10");
        check(self_ref_o == 1'b1, "R10", "entry", int'(self_ref_o), 1);
        step(P_ACT, 0, 2'b00, 0, "R10");
        step(P_MRS, 0, 2'b00, 0, "R10");
        step(P_NOP, 0, 2'b00, 1, "R10");
        check(cmd_o == 4'd4 && self_ref_o == 1'b0, "R10", "exit", int'(cmd_o), 4);
        step(P_NOP, 0, 2'b00, 1, "R1");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            r = int'($urandom % 16);
            case (r)
                0, 1, 2, 3: pins = P_ACT;
                4, 5:       pins = P_RD;
                6, 7:       pins = P_WR;
                8:          pins = P_PRE;
                9:          pins = P_BST;
                10:         pins = P_MRS;
                11:         pins = P_REF;
                default:    pins = P_NOP;
            endcase
            if ($urandom % 16 == 0) pins[3] = 1'b1;
            step(pins, 1'($urandom % 2), 2'($urandom % 4), ($urandom % 20) != 0, "");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule